// File: doc/BRIEF.md
# Shared PCI Interrupt Line Router

This block takes the level-sensitive INTx pins of a set of PCI devices and steers them onto sixteen legacy interrupt controller inputs. Each device sits in a slot, and its four INTx pins are rotated by that slot number onto four shared interrupt lines, called links A to D below. This rotation spreads the devices across the links. Every link has a byte-wide routing register. That register either names one controller input or marks the link as unconnected.

The block keeps a 64-bit level map with one bit for each pair of controller input and link. Bit index is `irq*4 + link`. Each output is the OR of its group of four bits. When software rewrites any routing register, the whole map is rebuilt from the current link levels. All outputs then reflect the new routing after one clock edge. Software writes the routing registers as one 32-bit configuration dword with byte enables. The block reports each link's route on status outputs.

Top module: `pirq_router`

## Requirements
- R1: After synchronous reset every routing register holds 0x80, so all four links are unconnected: `route_en` is 0, `route_irq` is 0 and `irq_out` is 0, whatever the device pins do.
- R2: A configuration write to dword address 0x18 (byte offsets 0x60 to 0x63) updates the routing register of link k (A=0 to D=3) from `cfg_wdata[8k+7:8k]` only when `cfg_be[k]` is 1. Lanes with a clear enable keep their value. A write to any other dword address changes no routing register.
- R3: `route_en[k]` is 1 exactly when link k's routing register is below 16. `route_irq[4k+3:4k]` then holds the register's low four bits; otherwise it is 0.
- R4: INTx pin n (A=0 to D=3) of a device in slot s drives link (n + s - 1) mod 4. A link's level is the OR of every device pin mapped to it.
- R5: `irq_out[i]` is 1 exactly when some connected link routed to input i has its level high.
- R6: A link whose routing register is 16 or more (for example 0x10, 0x80, 0xFF) has no effect on any output.
- R7: When two links are routed to the same input, that output stays high until both links are low.
- R8: After a routing write, the outputs reflect the new routing and the current link levels at the next clock edge. A held-high link moves from its old input to its new one in that same edge.
- R9: A change on a device pin appears on `irq_out` after exactly one rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_intx | input | 16 | INTx levels, bits 4d..4d+3 are pins A..D of device d |
| dev_slot | input | 20 | Slot number of each device, 5 bits per device |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Configuration dword address |
| cfg_be | input | 4 | Byte enables, one per routing register |
| cfg_wdata | input | 32 | Configuration write data |
| irq_out | output | 16 | Level outputs to the interrupt controller inputs |
| route_en | output | 4 | Per-link connected flag |
| route_irq | output | 16 | Per-link routed input number, 4 bits per link |

## Verification
A wrong bit in the level map shows on `irq_out` one edge after the input or routing change that caused it. It appears as a missing, extra or misplaced interrupt level. A stale bit left behind by a route change is the most likely fault, and it shows as the old input staying high after the write. A fault in a routing register appears on `route_en` and `route_irq` at the edge of the write. The shared-input and disabled-link cases are the ones that separate a true OR of the map from a simpler last-writer scheme.

// File: rtl/pirq_route_pkg.sv
// Shared constants and the slot rotation used by the interrupt router.
// Assumes the link count is a power of two.
package pirq_route_pkg;
    localparam int BYTE_W      = 8;
    localparam int DEF_LINKS   = 4;
    localparam int DEF_INPUTS  = 16;

    // One-hot link selected by pin `pin` of a device in slot `slot`.
    function automatic logic [DEF_LINKS-1:0] link_of(input int pin, input int slot);
        logic [DEF_LINKS-1:0] sel;
        sel = '0;
        sel[(pin + slot + DEF_LINKS - 1) % DEF_LINKS] = 1'b1;
        return sel;
    endfunction
endpackage

// File: rtl/pirq_link_swizzle.sv
// Rotates each device's INTx pins onto the shared links by slot number and
// ORs all pins landing on one link. Purely combinational.
// Assumes NUM_LINK matches the package rotation width.
module pirq_link_swizzle
    import pirq_route_pkg::*;
#(
    parameter int NUM_DEV  = 4,
    parameter int SLOT_W   = 5,
    parameter int NUM_LINK = DEF_LINKS
) (
    input  logic [NUM_DEV*NUM_LINK-1:0] dev_intx,
    input  logic [NUM_DEV*SLOT_W-1:0]   dev_slot,
    output logic [NUM_LINK-1:0]         link_lvl
);
    // OR every asserted pin into its rotated link
    always_comb begin
        link_lvl = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            for (int n = 0; n < NUM_LINK; n++) begin
                if (dev_intx[d*NUM_LINK + n])
                    link_lvl = link_lvl |
                        link_of(n, int'(dev_slot[d*SLOT_W +: SLOT_W]));
            end
        end
    end
endmodule

// File: rtl/pirq_route_regs.sv
// Holds one byte-wide routing register per link, written through a dword
// configuration port with byte enables. Also decodes the route status.
// Assumes one dword holds all link registers (NUM_LINK <= 4).
module pirq_route_regs
    import pirq_route_pkg::*;
#(
    parameter int             NUM_LINK = DEF_LINKS,
    parameter int             NUM_IRQ  = DEF_INPUTS,
    parameter int             ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] ROUTE_DW = 6'h18,
    localparam int            IRQ_W    = $clog2(NUM_IRQ),
    localparam int            REG_W    = NUM_LINK*BYTE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [ADDR_W-1:0]         cfg_dw_addr,
    input  logic [NUM_LINK-1:0]       cfg_be,
    input  logic [REG_W-1:0]          cfg_wdata,
    output logic [REG_W-1:0]          route_nx,
    output logic [NUM_LINK-1:0]       route_en,
    output logic [NUM_LINK*IRQ_W-1:0] route_irq
);
    localparam logic [BYTE_W-1:0] RST_VAL = 8'h80;
    localparam logic [BYTE_W-1:0] IRQ_LIM = BYTE_W'(NUM_IRQ);

    logic [REG_W-1:0] route_q;
    logic             cfg_hit;

    // Write strobe addressed at the routing dword
    assign cfg_hit = cfg_we && (cfg_dw_addr == ROUTE_DW);

    // Merge enabled byte lanes into the next register image
    always_comb begin
        route_nx = route_q;
        for (int k = 0; k < NUM_LINK; k++)
            if (cfg_hit && cfg_be[k])
                route_nx[k*BYTE_W +: BYTE_W] = cfg_wdata[k*BYTE_W +: BYTE_W];
    end

    // Register the routing bytes, all links unconnected after reset
    always_ff @(posedge clk) begin
        if (!rst_n) route_q <= {NUM_LINK{RST_VAL}};
        else        route_q <= route_nx;
    end

    for (genvar k = 0; k < NUM_LINK; k++) begin : g_stat
        logic [BYTE_W-1:0] rb;
        assign rb = route_q[k*BYTE_W +: BYTE_W];
        // Decode connected flag and routed input number
        assign route_en[k]                = (rb < IRQ_LIM);
        assign route_irq[k*IRQ_W +: IRQ_W] = (rb < IRQ_LIM) ? rb[IRQ_W-1:0] : '0;

        // R2
        lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_hit && !cfg_be[k]) |=> $stable(route_q[k*BYTE_W +: BYTE_W]));
    end

    // R2
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_hit |=> $stable(route_q));
endmodule

// File: rtl/pirq_level_map.sv
// Keeps the input-by-link level map. Each bit is set when its link is high
// and routed to that input. The map is rebuilt every edge from the routing
// image being written, so a routing write leaves no stale bits behind.
// Each output ORs its group of NUM_LINK bits.
// Assumes route_nx is the register image that takes effect at this edge.
module pirq_level_map
    import pirq_route_pkg::*;
#(
    parameter int  NUM_LINK = DEF_LINKS,
    parameter int  NUM_IRQ  = DEF_INPUTS,
    localparam int IRQ_W    = $clog2(NUM_IRQ),
    localparam int MAP_W    = NUM_IRQ*NUM_LINK
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LINK*BYTE_W-1:0] route_nx,
    input  logic [NUM_LINK-1:0]        route_en,
    input  logic [NUM_LINK-1:0]        link_lvl,
    output logic [NUM_IRQ-1:0]         irq_out
);
    localparam logic [BYTE_W-1:0] IRQ_LIM = BYTE_W'(NUM_IRQ);

    logic [MAP_W-1:0] lvl_map;
    logic [MAP_W-1:0] map_nx;

    // Full rebuild of the map from next routes and present link levels
    always_comb begin
        map_nx = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            for (int p = 0; p < NUM_LINK; p++) begin
                if (link_lvl[p] &&
                    route_nx[p*BYTE_W +: BYTE_W] < IRQ_LIM &&
                    route_nx[p*BYTE_W +: IRQ_W] == IRQ_W'(i))
                    map_nx[i*NUM_LINK + p] = 1'b1;
            end
        end
    end

    // Hold the level map, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_map <= '0;
        else        lvl_map <= map_nx;
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_out
        // Each output is the OR of its group
        assign irq_out[i] = |lvl_map[i*NUM_LINK +: NUM_LINK];
    end

    for (genvar p = 0; p < NUM_LINK; p++) begin : g_col
        logic [NUM_IRQ-1:0] col;
        // Gather one link's bits across all inputs
        always_comb begin
            for (int i = 0; i < NUM_IRQ; i++) col[i] = lvl_map[i*NUM_LINK + p];
        end

        // R5
        single_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col));
        // R6
        disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !route_en[p] |-> (col == '0));
        // R9
        level_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|col) |-> $past(link_lvl[p]));
    end
endmodule

// File: rtl/pirq_router.sv
// Top level: device INTx pins, rotated onto shared links, routed onto legacy
// interrupt controller inputs by software-written routing registers.
// Assumes level-sensitive inputs, already synchronous to clk.
module pirq_router
    import pirq_route_pkg::*;
#(
    parameter int             NUM_DEV  = 4,
    parameter int             SLOT_W   = 5,
    parameter int             NUM_LINK = DEF_LINKS,
    parameter int             NUM_IRQ  = DEF_INPUTS,
    parameter int             ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] ROUTE_DW = 6'h18,
    localparam int            IRQ_W    = $clog2(NUM_IRQ)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_DEV*NUM_LINK-1:0]  dev_intx,
    input  logic [NUM_DEV*SLOT_W-1:0]    dev_slot,
    input  logic                         cfg_we,
    input  logic [ADDR_W-1:0]            cfg_dw_addr,
    input  logic [NUM_LINK-1:0]          cfg_be,
    input  logic [NUM_LINK*BYTE_W-1:0]   cfg_wdata,
    output logic [NUM_IRQ-1:0]           irq_out,
    output logic [NUM_LINK-1:0]          route_en,
    output logic [NUM_LINK*IRQ_W-1:0]    route_irq
);
    logic [NUM_LINK-1:0]        link_lvl;
    logic [NUM_LINK*BYTE_W-1:0] route_nx;

    pirq_link_swizzle #(.NUM_DEV(NUM_DEV), .SLOT_W(SLOT_W), .NUM_LINK(NUM_LINK)) u_swz (
        .dev_intx (dev_intx),
        .dev_slot (dev_slot),
        .link_lvl (link_lvl)
    );

    pirq_route_regs #(.NUM_LINK(NUM_LINK), .NUM_IRQ(NUM_IRQ),
                      .ADDR_W(ADDR_W), .ROUTE_DW(ROUTE_DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_dw_addr (cfg_dw_addr),
        .cfg_be      (cfg_be),
        .cfg_wdata   (cfg_wdata),
        .route_nx    (route_nx),
        .route_en    (route_en),
        .route_irq   (route_irq)
    );

    pirq_level_map #(.NUM_LINK(NUM_LINK), .NUM_IRQ(NUM_IRQ)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .route_nx (route_nx),
        .route_en (route_en),
        .link_lvl (link_lvl),
        .irq_out  (irq_out)
    );
endmodule

// File: tb/pirq_router_test.sv
`timescale 1ns/1ps
module pirq_router_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] dev_intx;
    logic [19:0] dev_slot;
    logic        cfg_we;
    logic [5:0]  cfg_dw_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [15:0] irq_out;
    logic [3:0]  route_en;
    logic [15:0] route_irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_route [4];

    always #2.5 clk = ~clk;

    pirq_router uut (
        .clk(clk), .rst_n(rst_n), .dev_intx(dev_intx), .dev_slot(dev_slot),
        .cfg_we(cfg_we), .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .irq_out(irq_out), .route_en(route_en),
        .route_irq(route_irq)
    );

    // Link levels from the rotation rule of R4
    function automatic logic [3:0] exp_links();
        logic [3:0] r = '0;
        for (int d = 0; d < 4; d++)
            for (int n = 0; n < 4; n++)
                if (dev_intx[d*4+n]) r[(n + int'(dev_slot[d*5 +: 5]) + 3) % 4] = 1'b1;
        return r;
    endfunction

    // Expected outputs per R5/R6
    function automatic logic [15:0] exp_irq();
        logic [15:0] r = '0;
        logic [3:0]  l = exp_links();
        for (int p = 0; p < 4; p++)
            if (l[p] && m_route[p] < 8'd16) r[m_route[p][3:0]] = 1'b1;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One clock; model the write, then compare at the falling edge
    task automatic step(input string tag);
        logic [3:0]  e_en;
        logic [15:0] e_irq;
        if (cfg_we && cfg_dw_addr == 6'h18)
            for (int k = 0; k < 4; k++)
                if (cfg_be[k]) m_route[k] = cfg_wdata[k*8 +: 8];
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            e_en[k] = m_route[k] < 8'd16;
            e_irq[k*4 +: 4] = e_en[k] ? m_route[k][3:0] : 4'h0;
        end
        chk({tag, " R5 irq_out"}, irq_out, exp_irq());
        chk({tag, " R3 route_en"}, {12'h0, route_en}, {12'h0, e_en});
        chk({tag, " R3 route_irq"}, route_irq, e_irq);
        cfg_we = 1'b0;
    endtask

    task automatic wr(input string tag, input logic [5:0] a, input logic [3:0] be,
                      input logic [31:0] d);
        cfg_we = 1'b1; cfg_dw_addr = a; cfg_be = be; cfg_wdata = d;
        step(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1357);
        rst_n = 1'b0; dev_intx = '0; dev_slot = '0;
        cfg_we = 1'b0; cfg_dw_addr = '0; cfg_be = '0; cfg_wdata = '0;
        for (int k = 0; k < 4; k++) m_route[k] = 8'h80;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq_out", irq_out, 16'h0);
        chk("R1 route_en", {12'h0, route_en}, 16'h0);
        chk("R1 route_irq", route_irq, 16'h0);
        dev_intx = 16'hFFFF; dev_slot = {5'd4, 5'd3, 5'd2, 5'd1};
        step("R1");
        chk("R1 pins ignored", irq_out, 16'h0);

        // R2 lane enables and address decode
        wr("R2", 6'h18, 4'b0101, 32'hFF0A_EE03);
        chk("R2 lanes", route_irq, 16'h0A03);
        wr("R2", 6'h19, 4'hF, 32'h0);
        chk("R2 other addr", route_irq, 16'h0A03);
        wr("R2", 6'h18, 4'h0, 32'h0);
        chk("R2 no lanes", {12'h0, route_en}, 16'h0005);

        // R4 slot rotation
        dev_intx = '0; dev_slot = '0;
        dev_intx[1] = 1'b1; dev_slot[4:0] = 5'd3;          // pin B, slot 3 -> link D
        wr("R4", 6'h18, 4'hF, 32'h0980_8080);
        chk("R4 slot3 pinB", irq_out, 16'h0200);
        dev_intx = '0; dev_intx[4] = 1'b1; dev_slot = '0;   // pin A, slot 0 -> link D
        step("R4");
        chk("R4 slot0 pinA", irq_out, 16'h0200);

        // R7 shared input
        dev_intx = 16'h0003; dev_slot = {15'h0, 5'd1};      // links A and B
        wr("R7", 6'h18, 4'hF, 32'h8080_0505);
        chk("R7 both", irq_out, 16'h0020);
        dev_intx = 16'h0002; step("R7");
        chk("R7 one left", irq_out, 16'h0020);
        dev_intx = 16'h0000; step("R7");
        chk("R7 none", irq_out, 16'h0000);

        // R8 routing move while held high
        dev_intx = 16'h0001; step("R8");
        wr("R8", 6'h18, 4'b0001, 32'h0000_000C);
        chk("R8 moved", irq_out, 16'h1000);

        // R6 disabled values
        wr("R6", 6'h18, 4'b0001, 32'h0000_0010);
        chk("R6 0x10", irq_out, 16'h0000);
        wr("R6", 6'h18, 4'b0001, 32'h0000_00FF);
        dev_intx = 16'h0000; step("R6");
        dev_intx = 16'h0001; step("R6");
        chk("R6 0xFF", irq_out, 16'h0000);

        // R9 one-edge latency
        wr("R9", 6'h18, 4'b0001, 32'h0000_0002);
        dev_intx = 16'h0000; step("R9");
        dev_intx = 16'h0001;
        #1 chk("R9 before edge", irq_out, 16'h0000);
        step("R9");
        chk("R9 after edge", irq_out, 16'h0004);

        // Random traffic checked against the model
        for (int it = 0; it < 400; it++) begin
            dev_intx = 16'($urandom);
            if ($urandom % 8 == 0) dev_slot = 20'($urandom);
            if ($urandom % 4 == 0) begin
                logic [31:0] d;
                for (int k = 0; k < 4; k++)
                    d[k*8 +: 8] = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 20);
                wr("RND", ($urandom % 6 == 0) ? 6'($urandom) : 6'h18, 4'($urandom), d);
            end else begin
                step("RND");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule